// File: doc/BRIEF.md
# String Transfer Element Sequencer

This block steps a repeated transfer between an I/O port and memory. A transfer is started with a one-cycle start pulse, together with its configuration: the start pointer, a segment base and limit, a direction flag, the element size (1, 2 or 4 bytes), the address size (16, 32 or 64 bits), whether the transfer goes from port to memory, whether the fast word path may be used, and the repeat count. The block then walks the pointer and the count down to zero. It gives one memory-access strobe per step and finishes with a done pulse.

For each step the block drives the linear address, which is the segment base plus the pointer truncated to the address size. A port-to-memory step first spends one cycle probing the destination address and then performs the transfer. When the element is a 2-byte word and the fast path is allowed, one step may move a whole burst of words. The burst is limited so that it stays inside the current 4 KiB page. It is refused when the linear address is odd, or when the page that holds the pointer extends past the segment limit. A refused burst falls back to a single element. After a burst the pointer moves by twice the burst length. The count is first reduced by the burst length minus one, and a separate tail cycle then removes the final unit.

Top module: `sio_string_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `probe_stb`, `xfer_stb` and `done` are low, and `ptr_out` and `cnt_out` are zero.
- R2: A start with a repeat count of zero produces `done` in the next cycle. No probe or transfer strobe is issued, and the pointer and count keep the start values.
- R3: A single-element step moves the pointer by the element size (`elem_size` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). The pointer decreases when `dir_down` is 1 and increases otherwise.
- R4: With `addr_size` 0 (16-bit), only pointer bits [15:0] change and they wrap modulo 65536. Bits above 15 keep their value, and the address uses only bits [15:0] of the pointer.
- R5: With `addr_size` 1 (32-bit), the updated pointer has bits above 31 cleared and the address uses bits [31:0] of the pointer. `addr_size` 2 or 3 uses the full pointer.
- R6: A burst (`xfer_fast` = 1) happens only when `fast_req` was set at start, the element size is 2 bytes and the linear address is even. In every other case the step is a single element with `xfer_len` = 1.
- R7: A burst is refused when the pointer offset with bits [11:0] forced to ones is greater than `seg_limit`. A burst is allowed when the two are equal.
- R8: When counting upward, the burst length is the smaller of the remaining count and (4096 minus address bits [11:0]) divided by 2.
- R9: When counting downward, the burst length is the smaller of the remaining count and (address bits [11:0] plus 2) divided by 2.
- R10: The transfer cycle of a burst of length L moves the pointer by 2*L and reduces the count by L-1. The following tail cycle reduces the count by one more.
- R11: For port-to-memory transfers (`to_memory` = 1), each transfer cycle is preceded by a probe cycle (`probe_stb`) that shows the same address.
- R12: When the count reaches zero, `done` pulses for one cycle and the block returns to idle. A start pulse that arrives while `busy` is high is ignored.
- R13: `xfer_addr` equals `seg_base` plus the pointer truncated to the address size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a transfer while idle |
| start_ptr | input | ADDR_W | Initial pointer |
| seg_base | input | ADDR_W | Segment base added to form the linear address |
| seg_limit | input | LIM_W | Scaled segment limit used by the fast-path check |
| dir_down | input | 1 | 1 = pointer decreases, 0 = pointer increases |
| elem_size | input | 2 | 0 = byte, 1 = word, 2/3 = doubleword |
| addr_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2/3 = 64-bit |
| to_memory | input | 1 | 1 = port-to-memory (a probe precedes each step) |
| fast_req | input | 1 | Allows the burst path for word elements |
| rep_count | input | CNT_W | Repeat count |
| busy | output | 1 | A transfer is in progress |
| probe_stb | output | 1 | Destination probe cycle |
| xfer_stb | output | 1 | Transfer cycle for one element or one burst |
| xfer_addr | output | ADDR_W | Linear address of the probe or transfer |
| xfer_len | output | CNT_W | Elements moved in this transfer cycle |
| xfer_fast | output | 1 | This transfer cycle is a page-clipped burst |
| ptr_out | output | ADDR_W | Current pointer |
| cnt_out | output | CNT_W | Current count |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a burst that stops exactly at a page edge and is followed by a second burst that starts at offset 0 (upward) or 0xFFE (downward). This happens only when the start offset, the direction and the count are chosen together. The stimulus starts a few words before a page edge with a count that is larger than the words left in that page, in both directions. It also places the segment limit one below and exactly at the end of the page, so that the refusal decision switches between the two settings. A behavioural model in the bench follows each of these runs cycle by cycle.

// File: rtl/sio_pkg.sv
// Package: shared encodings for the string transfer sequencer.
// Assumes: encodings below match the port descriptions of the top module.
package sio_pkg;
    localparam int PAGE_BITS = 12;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_WORD  = 2'd1,
        ESZ_DWORD = 2'd2,
        ESZ_DWALT = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        ASZ_16  = 2'd0,
        ASZ_32  = 2'd1,
        ASZ_64  = 2'd2,
        ASZ_64B = 2'd3
    } asz_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROBE = 3'd1,
        ST_EXEC  = 3'd2,
        ST_TAIL  = 3'd3,
        ST_DONE  = 3'd4
    } st_e;
endpackage

// File: rtl/sio_addr_unit.sv
// Module: sio_addr_unit
// Forms the effective offset and linear address from the pointer, and the
// next pointer after a step of len elements in the chosen direction.
// Assumes: ADDR_W >= 32; len is 1 for single steps and the burst length otherwise.
module sio_addr_unit
    import sio_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [1:0]        asz,
    input  logic [1:0]        esz,
    input  logic              down,
    input  logic [CNT_W-1:0]  len,
    output logic [ADDR_W-1:0] eff_off,
    output logic [ADDR_W-1:0] lin_addr,
    output logic [ADDR_W-1:0] ptr_next
);
    localparam int HI_W = ADDR_W - 32;

    logic [1:0]        shamt;
    logic [ADDR_W-1:0] delta;
    logic [ADDR_W-1:0] raw;

    // Byte-size shift for the element width.
    always_comb begin
        case (esz)
            ESZ_BYTE: shamt = 2'd0;
            ESZ_WORD: shamt = 2'd1;
            default:  shamt = 2'd2;
        endcase
    end

    // Full-width stepped pointer before address-size masking.
    always_comb begin
        delta = ADDR_W'(len) << shamt;
        raw   = down ? (ptr - delta) : (ptr + delta);
    end

    generate
        if (ADDR_W > 32) begin : g_wide
            // Address-size masking of offset and write-back, wide pointer.
            always_comb begin
                case (asz)
                    ASZ_16: begin
                        eff_off  = {{(ADDR_W-16){1'b0}}, ptr[15:0]};
                        ptr_next = {ptr[ADDR_W-1:16], raw[15:0]};
                    end
                    ASZ_32: begin
                        eff_off  = {{HI_W{1'b0}}, ptr[31:0]};
                        ptr_next = {{HI_W{1'b0}}, raw[31:0]};
                    end
                    default: begin
                        eff_off  = ptr;
                        ptr_next = raw;
                    end
                endcase
            end
        end else begin : g_narrow
            // Address-size masking when the pointer is only 32 bits wide.
            always_comb begin
                case (asz)
                    ASZ_16: begin
                        eff_off  = {{(ADDR_W-16){1'b0}}, ptr[15:0]};
                        ptr_next = {ptr[ADDR_W-1:16], raw[15:0]};
                    end
                    default: begin
                        eff_off  = ptr;
                        ptr_next = raw;
                    end
                endcase
            end
        end
    endgenerate

    // Linear address seen by memory.
    always_comb lin_addr = seg_base + eff_off;
endmodule

// File: rtl/sio_page_clip.sv
// Module: sio_page_clip
// Decides whether a word burst is allowed and how many words it moves so the
// burst stays inside one page; otherwise reports a single-element step.
// Assumes: CNT_W > PAGE_BITS, ADDR_W >= LIM_W; clk/rst_n serve the checks only.
module sio_page_clip
    import sio_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32,
    parameter int LIM_W  = 32,
    parameter int PG_W   = PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PG_W-1:0]   pg_off,
    input  logic [ADDR_W-1:0] eff_off,
    input  logic [LIM_W-1:0]  seg_limit,
    input  logic              down,
    input  logic [1:0]        esz,
    input  logic              fast_req,
    input  logic [CNT_W-1:0]  cnt,
    output logic              fast_ok,
    output logic [CNT_W-1:0]  len_eff
);
    localparam int                FIT_W     = PG_W + 1;
    localparam logic [FIT_W-1:0]  PAGE_SIZE = FIT_W'(1) << PG_W;
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PG_W) - 64'd1);
    localparam int                CHK_W     = CNT_W + 2;

    logic [FIT_W-1:0] fit_up;
    logic [FIT_W-1:0] fit_dn;
    logic [CNT_W-1:0] fit_ext;
    logic [CNT_W-1:0] clip;
    logic             over_limit;
    logic             eligible;

    // Words left in the page for each direction.
    always_comb begin
        fit_up  = (PAGE_SIZE - {1'b0, pg_off}) >> 1;
        fit_dn  = ({1'b0, pg_off} + FIT_W'(2)) >> 1;
        fit_ext = CNT_W'(down ? fit_dn : fit_up);
    end

    // Whole-page segment limit check.
    always_comb over_limit = (eff_off | PAGE_MASK) > ADDR_W'(seg_limit);

    // Burst eligibility and clipped length with single-element fallback.
    always_comb begin
        clip     = (cnt < fit_ext) ? cnt : fit_ext;
        eligible = fast_req && (esz == ESZ_WORD) && !pg_off[0] && !over_limit;
        fast_ok  = eligible && (clip != '0);
        len_eff  = fast_ok ? clip : CNT_W'(1);
    end

    logic [CHK_W-1:0] span_bytes;
    logic [CHK_W-1:0] off_ext;
    always_comb begin
        span_bytes = CHK_W'(len_eff) << 1;
        off_ext    = CHK_W'(pg_off);
    end

    // R8
    up_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_ok && !down) |-> ((off_ext + span_bytes) <= CHK_W'(PAGE_SIZE)));
    // R9
    dn_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_ok && down) |-> (span_bytes <= (off_ext + CHK_W'(2))));
    // R8
    burst_le_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_ok |-> ((len_eff <= cnt) && (len_eff != '0)));
endmodule

// File: rtl/sio_ctrl.sv
// Module: sio_ctrl
// Holds the transfer configuration, pointer and count, and sequences the
// probe / transfer / tail cycles until the count reaches zero.
// Assumes: ptr_next and len_eff are combinational from the registered state.
module sio_ctrl
    import sio_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32,
    parameter int LIM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [LIM_W-1:0]  start_limit,
    input  logic              start_down,
    input  logic [1:0]        start_esz,
    input  logic [1:0]        start_asz,
    input  logic              start_to_mem,
    input  logic              start_fast,
    input  logic [CNT_W-1:0]  rep_count,
    input  logic [ADDR_W-1:0] ptr_next,
    input  logic [CNT_W-1:0]  len_eff,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [LIM_W-1:0]  limit_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              down_q,
    output logic [1:0]        esz_q,
    output logic [1:0]        asz_q,
    output logic              fast_q,
    output logic              busy,
    output logic              probe_stb,
    output logic              xfer_stb,
    output logic              done
);
    st_e  state, state_nxt;
    logic to_mem_q;

    // Next-state selection for the step sequence.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE: if (start) begin
                if (rep_count == '0)  state_nxt = ST_DONE;
                else if (start_to_mem) state_nxt = ST_PROBE;
                else                   state_nxt = ST_EXEC;
            end
            ST_PROBE: state_nxt = ST_EXEC;
            ST_EXEC:  state_nxt = ST_TAIL;
            ST_TAIL: begin
                if (cnt_q == CNT_W'(1)) state_nxt = ST_DONE;
                else if (to_mem_q)      state_nxt = ST_PROBE;
                else                    state_nxt = ST_EXEC;
            end
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Configuration capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            limit_q  <= '0;
            down_q   <= 1'b0;
            esz_q    <= 2'd0;
            asz_q    <= 2'd0;
            to_mem_q <= 1'b0;
            fast_q   <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            base_q   <= start_base;
            limit_q  <= start_limit;
            down_q   <= start_down;
            esz_q    <= start_esz;
            asz_q    <= start_asz;
            to_mem_q <= start_to_mem;
            fast_q   <= start_fast;
        end
    end

    // Pointer and count updates: load, step/burst, tail decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ptr_q <= start_ptr;
                    cnt_q <= rep_count;
                end
                ST_EXEC: begin
                    ptr_q <= ptr_next;
                    cnt_q <= cnt_q - (len_eff - CNT_W'(1));
                end
                ST_TAIL: cnt_q <= cnt_q - CNT_W'(1);
                default: ;
            endcase
        end
    end

    // Strobe decode from the current state.
    always_comb begin
        busy      = (state != ST_IDLE);
        probe_stb = (state == ST_PROBE);
        xfer_stb  = (state == ST_EXEC);
        done      = (state == ST_DONE);
    end

    // R12
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R11
    probe_before_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && to_mem_q) |-> ($past(probe_stb) && $stable(ptr_q)));
    // R10
    tail_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    // R10
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cnt_q <= $past(cnt_q)));
    // R4
    low16_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && asz_q == ASZ_16) |=> (ptr_q[ADDR_W-1:16] == $past(ptr_q[ADDR_W-1:16])));
    // R5
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && asz_q == ASZ_32) |=> (ptr_q[ADDR_W-1:32] == '0));
endmodule

// File: rtl/sio_string_seq.sv
// Module: sio_string_seq (top)
// Sequences a repeated port/memory string transfer, one element or one
// page-clipped word burst per transfer cycle.
// Assumes: start is honoured only while busy is low; ADDR_W >= 33.
module sio_string_seq
    import sio_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32,
    parameter int LIM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [LIM_W-1:0]  seg_limit,
    input  logic              dir_down,
    input  logic [1:0]        elem_size,
    input  logic [1:0]        addr_size,
    input  logic              to_memory,
    input  logic              fast_req,
    input  logic [CNT_W-1:0]  rep_count,
    output logic              busy,
    output logic              probe_stb,
    output logic              xfer_stb,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [CNT_W-1:0]  xfer_len,
    output logic              xfer_fast,
    output logic [ADDR_W-1:0] ptr_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              done
);
    logic [ADDR_W-1:0] ptr_q, base_q, eff_off, lin_addr, ptr_next;
    logic [LIM_W-1:0]  limit_q;
    logic [CNT_W-1:0]  cnt_q, len_eff;
    logic              down_q, fast_q, fast_ok;
    logic [1:0]        esz_q, asz_q;

    sio_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LIM_W(LIM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_ptr(start_ptr), .start_base(seg_base), .start_limit(seg_limit),
        .start_down(dir_down), .start_esz(elem_size), .start_asz(addr_size),
        .start_to_mem(to_memory), .start_fast(fast_req), .rep_count(rep_count),
        .ptr_next(ptr_next), .len_eff(len_eff),
        .ptr_q(ptr_q), .base_q(base_q), .limit_q(limit_q), .cnt_q(cnt_q),
        .down_q(down_q), .esz_q(esz_q), .asz_q(asz_q), .fast_q(fast_q),
        .busy(busy), .probe_stb(probe_stb), .xfer_stb(xfer_stb), .done(done)
    );

    sio_addr_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .ptr(ptr_q), .seg_base(base_q), .asz(asz_q), .esz(esz_q),
        .down(down_q), .len(len_eff),
        .eff_off(eff_off), .lin_addr(lin_addr), .ptr_next(ptr_next)
    );

    sio_page_clip #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LIM_W(LIM_W)) u_clip (
        .clk(clk), .rst_n(rst_n),
        .pg_off(lin_addr[PAGE_BITS-1:0]), .eff_off(eff_off), .seg_limit(limit_q),
        .down(down_q), .esz(esz_q), .fast_req(fast_q), .cnt(cnt_q),
        .fast_ok(fast_ok), .len_eff(len_eff)
    );

    // Output drive: address, burst length and pointer/count view.
    always_comb begin
        xfer_addr = lin_addr;
        xfer_len  = xfer_stb ? len_eff : '0;
        xfer_fast = xfer_stb && fast_ok;
        ptr_out   = ptr_q;
        cnt_out   = cnt_q;
    end

    // R6
    fast_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_fast |-> !xfer_addr[0]);
    // R6
    single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !xfer_fast) |-> (xfer_len == CNT_W'(1)));
endmodule

// File: tb/sio_string_seq_tb.sv
module sio_string_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] start_ptr = '0, seg_base = '0;
    logic [31:0] seg_limit = '0, rep_count = '0;
    logic        dir_down = 1'b0, to_memory = 1'b0, fast_req = 1'b0;
    logic [1:0]  elem_size = '0, addr_size = '0;
    logic        busy, probe_stb, xfer_stb, xfer_fast, done;
    logic [63:0] xfer_addr, ptr_out;
    logic [31:0] xfer_len, cnt_out;

    sio_string_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
        .seg_base(seg_base), .seg_limit(seg_limit), .dir_down(dir_down),
        .elem_size(elem_size), .addr_size(addr_size), .to_memory(to_memory),
        .fast_req(fast_req), .rep_count(rep_count),
        .busy(busy), .probe_stb(probe_stb), .xfer_stb(xfer_stb),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_fast(xfer_fast),
        .ptr_out(ptr_out), .cnt_out(cnt_out), .done(done)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;
    int    beats = 0;
    int    fast_beats = 0;
    longint unsigned first_addr = 0;

    // Reference model state: 0 idle, 1 probe, 2 transfer, 3 tail, 4 done.
    int              m_phase = 0;
    longint unsigned m_ptr = 0, m_base = 0, m_cnt = 0, m_lim = 0;
    bit              m_down = 0, m_in = 0, m_fast = 0;
    int              m_esz = 0, m_asz = 0;

    function automatic longint unsigned f_eff(longint unsigned p, int asz);
        if (asz == 0) return p & 64'hFFFF;
        if (asz == 1) return p & 64'hFFFF_FFFF;
        return p;
    endfunction

    function automatic longint unsigned f_lin();
        return m_base + f_eff(m_ptr, m_asz);
    endfunction

    function automatic bit f_elig();
        longint unsigned l = f_lin();
        return m_fast && (m_esz == 1) && (l % 2 == 0) &&
               ((f_eff(m_ptr, m_asz) | 64'hFFF) <= m_lim);
    endfunction

    function automatic longint unsigned f_len();
        longint unsigned pg, fit;
        if (!f_elig()) return 1;
        pg  = f_lin() % 4096;
        fit = m_down ? (pg + 2) / 2 : (4096 - pg) / 2;
        return (m_cnt < fit) ? m_cnt : fit;
    endfunction

    function automatic longint unsigned f_step(longint unsigned n);
        longint unsigned bytes, np;
        bytes = n * ((m_esz == 0) ? 1 : (m_esz == 1) ? 2 : 4);
        np = m_down ? m_ptr - bytes : m_ptr + bytes;
        if (m_asz == 0) return (m_ptr & ~64'hFFFF) | (np & 64'hFFFF);
        if (m_asz == 1) return np & 64'hFFFF_FFFF;
        return np;
    endfunction

    // Model advance on each rising edge.
    always @(posedge clk) begin
        longint unsigned n;
        if (!rst_n) begin
            m_phase = 0; m_ptr = 0; m_cnt = 0;
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_ptr = start_ptr; m_cnt = rep_count; m_base = seg_base;
                    m_lim = seg_limit; m_down = dir_down; m_in = to_memory;
                    m_fast = fast_req; m_esz = elem_size; m_asz = addr_size;
                    m_phase = (rep_count == 0) ? 4 : (to_memory ? 1 : 2);
                end
                1: m_phase = 2;
                2: begin
                    n = f_len();
                    m_ptr = f_step(n);
                    m_cnt = m_cnt - (n - 1);
                    m_phase = 3;
                end
                3: begin
                    m_cnt = m_cnt - 1;
                    m_phase = (m_cnt == 0) ? 4 : (m_in ? 1 : 2);
                end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle compare against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(cur_req, "busy", 64'(busy), 64'(m_phase != 0));
            chk(cur_req, "probe_stb", 64'(probe_stb), 64'(m_phase == 1));
            chk(cur_req, "xfer_stb", 64'(xfer_stb), 64'(m_phase == 2));
            chk(cur_req, "done", 64'(done), 64'(m_phase == 4));
            chk(cur_req, "ptr_out", ptr_out, m_ptr);
            chk(cur_req, "cnt_out", 64'(cnt_out), m_cnt);
            if (m_phase == 1 || m_phase == 2)
                chk(cur_req, "xfer_addr (R13)", xfer_addr, f_lin());
            if (m_phase == 2) begin
                chk(cur_req, "xfer_len", 64'(xfer_len), f_len());
                chk(cur_req, "xfer_fast", 64'(xfer_fast), 64'(f_elig()));
            end
        end
        if (xfer_stb) begin
            beats++;
            if (xfer_fast) fast_beats++;
            if (beats == 1) first_addr = xfer_addr;
        end
    end

    task automatic run(string req, longint unsigned p, longint unsigned b, longint unsigned lim,
                       bit dn, int esz, int asz, bit tomem, bit fst, longint unsigned n,
                       bit poke_busy);
        int w;
        cur_req = req;
        @(negedge clk);
        beats = 0; fast_beats = 0;
        start_ptr = p; seg_base = b; seg_limit = 32'(lim); dir_down = dn;
        elem_size = 2'(esz); addr_size = 2'(asz); to_memory = tomem;
        fast_req = fst; rep_count = 32'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            start = 1'b1; start_ptr = 64'h9999; rep_count = 32'd50;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (m_phase != 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 20000) chk(req, "run timeout", 64'd1, 64'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while reset is held
        chk("R1", "busy in reset", 64'(busy), 64'd0);
        chk("R1", "strobes in reset", 64'({probe_stb, xfer_stb, done}), 64'd0);
        chk("R1", "ptr in reset", ptr_out, 64'd0);
        chk("R1", "cnt in reset", 64'(cnt_out), 64'd0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);

        // R2 zero count
        run("R2", 64'h40, 0, 32'hFFFF_FFFF, 0, 0, 2, 0, 0, 0, 0);
        chk("R2", "no beats", 64'(beats), 64'd0);
        chk("R2", "ptr kept", ptr_out, 64'h40);

        // R3 bytes upward, outbound
        run("R3", 64'h100, 0, 32'hFFFF_FFFF, 0, 0, 2, 0, 0, 3, 0);
        chk("R3", "byte up final ptr", ptr_out, 64'h103);
        chk("R3", "byte up beats", 64'(beats), 64'd3);

        // R3 R11 doublewords downward, inbound with probes
        run("R11", 64'h200, 0, 32'hFFFF_FFFF, 1, 2, 2, 1, 0, 2, 0);
        chk("R3", "dword down final ptr", ptr_out, 64'h1F8);

        // R4 16-bit wrap keeps upper bits
        run("R4", 64'h1_0000_FFFF, 64'h500, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 2, 0);
        chk("R4", "wrapped ptr", ptr_out, 64'h1_0000_0001);
        chk("R4", "first addr", 64'(first_addr), 64'h500 + 64'hFFFF);

        // R5 32-bit clears upper bits
        run("R5", 64'hABCD_0000_0000_0010, 0, 32'hFFFF_FFFF, 0, 1, 1, 0, 0, 1, 0);
        chk("R5", "upper cleared", ptr_out, 64'h12);

        // R8 R10 upward burst up to the page edge, then a second burst
        run("R8", 64'h1FF0, 0, 32'hFFFF, 0, 1, 1, 0, 1, 100, 0);
        chk("R10", "up burst final ptr", ptr_out, 64'h20B8);
        chk("R8", "up burst beats", 64'(beats), 64'd2);
        chk("R10", "up burst cnt", 64'(cnt_out), 64'd0);

        // R9 downward burst from 0x006 in the page, inbound
        run("R9", 64'h3006, 0, 32'hFFFF, 1, 1, 1, 1, 1, 10, 0);
        chk("R9", "down burst final ptr", ptr_out, 64'h2FF2);
        chk("R9", "down burst beats", 64'(fast_beats), 64'd2);

        // R6 odd linear address refuses the burst
        run("R6", 64'h100, 64'h1, 32'hFFFF, 0, 1, 1, 0, 1, 3, 0);
        chk("R6", "odd refuses", 64'(fast_beats), 64'd0);
        chk("R6", "odd final ptr", ptr_out, 64'h106);

        // R6 byte elements never burst
        run("R6", 64'h10, 0, 32'hFFFF, 0, 0, 1, 0, 1, 4, 0);
        chk("R6", "byte beats", 64'(beats), 64'd4);

        // R7 limit one below page end refuses, at page end accepts
        run("R7", 64'h1000, 0, 32'h1FFE, 0, 1, 1, 0, 1, 3, 0);
        chk("R7", "limit refuse beats", 64'(beats), 64'd3);
        chk("R7", "limit refuse ptr", ptr_out, 64'h1006);
        run("R7", 64'h1000, 0, 32'h1FFF, 0, 1, 1, 0, 1, 3, 0);
        chk("R7", "limit accept beats", 64'(fast_beats), 64'd1);

        // R12 start ignored while busy
        run("R12", 64'h700, 0, 32'hFFFF, 0, 0, 1, 1, 0, 3, 1);
        chk("R12", "ptr after ignored start", ptr_out, 64'h703);
        chk("R12", "idle at end", 64'(busy), 64'd0);

        // R13 base added to the offset
        run("R13", 64'h20, 64'h1000_0000, 32'hFFFF, 0, 0, 1, 0, 0, 1, 0);
        chk("R13", "based address", 64'(first_addr), 64'h1000_0020);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog %s actual=running expected=finished", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule